// File: doc/BRIEF.md
# Four-Channel DMA Register Front End

This block is the software-visible register file of a four-channel DMA controller that sits on an 8-bit I/O bus. A 4-bit port offset together with separate read and write strobes selects one of sixteen byte-wide ports. Each channel keeps 16-bit base and current copies of a transfer address and a transfer count, plus a 6-bit mode field. Every 16-bit quantity is moved through its 8-bit port as two back-to-back byte accesses. A shared byte-pointer flip-flop picks which half each access hits.

A downstream transfer engine reports each completed bus cycle on a step input, naming the channel it served. The block then moves that channel's current address by one and lowers its current count by one. When the count passes below zero it raises a terminal-count pulse. Depending on the channel's mode, it either reloads the channel from its base registers or masks the channel. The engine reads the mask and mode outputs to decide which channels may request the bus.

Top module: `dmac_regfile`

## Requirements
- R1: Reset and an idle read. After reset all four mask bits are 1, and every mode, request bit, terminal-count flag and address or count register is 0. The pointer is on the low byte. `rdata` is 0 whenever `rd_en` is low, and `tc_o` is 0.
- R2: The byte pointer works as follows.
  - Any read or write to offsets 0x0 to 0x7 toggles the pointer.
  - The first byte of a pair is the low byte and the second is the high byte.
  - A write to offset 0xC puts the pointer back on the low byte.
- R3: The address of channel n sits at offset 2n and its count at offset 2n+1. A write loads the selected byte into both the base and the current register. A read returns the selected byte of the current register.
- R4: The mask can be changed three ways.
  - Offset 0xA changes one bit: `wdata[1:0]` is the channel and `wdata[2]` is the new value, where 1 masks the channel.
  - Offset 0xE clears all four bits.
  - Offset 0xF loads all four bits from `wdata[3:0]`.
- R5: A write to offset 0xB stores `wdata[7:2]` as the mode of channel `wdata[1:0]`. In the byte, bit 4 selects auto-reload and bit 5 selects a decrementing address. The stored field of channel n appears at `mode_o[6n+5:6n]`.
- R6: A step on an unmasked channel does two things at the next edge, both wrapping within 16 bits.
  - The current address goes up by 1, or down by 1 when address decrement is selected.
  - The current count goes down by 1.
- R7: A step that names a masked channel changes no address or count and raises no terminal count.
- R8: A step on a channel whose current count is 0x0000 leaves the count at 0xFFFF. In the cycle after that edge, `tc_o` has exactly that channel's bit set for one cycle.
- R9: The effect of terminal count depends on the mode.
  - Without auto-reload, terminal count sets the channel's mask bit.
  - With auto-reload, terminal count copies the base address and base count into the current registers, and the mask is left unchanged.
- R10: A read at offset 0x8 returns the request bits in [7:4] and the sticky terminal-count flags in [3:0]. The read clears the flags.
- R11: A write to offset 0x9 sets request bit `wdata[1:0]` to the value of `wdata[2]`.
- R12: A write to offset 0xD does the following.
  - It puts the pointer on the low byte.
  - It sets all mask bits.
  - It clears all modes, request bits and flags.
  - It leaves addresses and counts unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_off | input | 4 | Port offset of the current access |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data byte, combinational, 0 when not reading |
| step_valid | input | 1 | One transfer completed this cycle |
| step_ch | input | 2 | Channel that completed the transfer |
| mask_o | output | 4 | Per-channel mask, 1 = masked |
| mode_o | output | 24 | Stored mode field of each channel, 6 bits each |
| tc_o | output | 4 | One-cycle terminal-count pulse per channel |

## Verification
The assertions watch several behaviours on every cycle:
- the pointer clears on a clear or master-clear write and toggles on each channel-port access;
- the mask is all set after a master clear and all clear after a clear-all write;
- `tc_o` has at most one bit set, only after a step, and never after a step on a masked channel;
- `rdata` is 0 while `rd_en` is low.

The register values themselves can only be shown by the bench scenarios. These cover byte ordering through the pointer, wrap at 0xFFFF, the decrement and auto-reload modes, the choice between masking and reloading at terminal count, status-flag clearing on read, and the fact that master clear keeps addresses.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam int NCH    = 4;
  localparam int CHW    = $clog2(NCH);
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam int MODE_W = 6;
  // bit positions inside the stored mode field (byte bits 4 and 5)
  localparam int MODE_AUTO = 2;
  localparam int MODE_DEC  = 3;
  // port offsets
  localparam logic [3:0] OFF_STAT   = 4'h8;
  localparam logic [3:0] OFF_REQ    = 4'h9;
  localparam logic [3:0] OFF_MASK1  = 4'hA;
  localparam logic [3:0] OFF_MODE   = 4'hB;
  localparam logic [3:0] OFF_PCLR   = 4'hC;
  localparam logic [3:0] OFF_MCLR   = 4'hD;
  localparam logic [3:0] OFF_MCLRAL = 4'hE;
  localparam logic [3:0] OFF_MALL   = 4'hF;
endpackage

// File: rtl/dmac_ptr_ff.sv
module dmac_ptr_ff (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tog,
  output logic hi_q
);
  logic hi_d;

  always_comb begin
    hi_d = hi_q;
    if (clr)      hi_d = 1'b0;
    else if (tog) hi_d = ~hi_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_q <= 1'b0;
    else        hi_q <= hi_d;
  end
endmodule

// File: rtl/dmac_chan.sv
module dmac_chan
  import dmac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_wr,
  input  logic              cnt_wr,
  input  logic              hi_sel,
  input  logic [BYTE_W-1:0] wbyte,
  input  logic              mode_wr,
  input  logic [MODE_W-1:0] mode_in,
  input  logic              mclr,
  input  logic              step,
  output logic [WORD_W-1:0] cur_addr,
  output logic [WORD_W-1:0] cur_cnt,
  output logic [MODE_W-1:0] mode_q,
  output logic              tc
);
  logic [WORD_W-1:0] base_addr, base_cnt;
  logic [WORD_W-1:0] base_addr_d, base_cnt_d, cur_addr_d, cur_cnt_d;
  logic [MODE_W-1:0] mode_d;
  logic              auto_rl, addr_dec;

  assign auto_rl  = mode_q[MODE_AUTO];
  assign addr_dec = mode_q[MODE_DEC];
  assign tc       = step && (cur_cnt == '0);

  always_comb begin
    base_addr_d = base_addr;
    base_cnt_d  = base_cnt;
    cur_addr_d  = cur_addr;
    cur_cnt_d   = cur_cnt;
    if (step) begin
      cur_addr_d = addr_dec ? cur_addr - 1'b1 : cur_addr + 1'b1;
      cur_cnt_d  = cur_cnt - 1'b1;
      if (tc && auto_rl) begin
        cur_addr_d = base_addr;
        cur_cnt_d  = base_cnt;
      end
    end
    if (addr_wr) begin
      if (hi_sel) begin
        base_addr_d[WORD_W-1:BYTE_W] = wbyte;
        cur_addr_d[WORD_W-1:BYTE_W]  = wbyte;
      end else begin
        base_addr_d[BYTE_W-1:0] = wbyte;
        cur_addr_d[BYTE_W-1:0]  = wbyte;
      end
    end
    if (cnt_wr) begin
      if (hi_sel) begin
        base_cnt_d[WORD_W-1:BYTE_W] = wbyte;
        cur_cnt_d[WORD_W-1:BYTE_W]  = wbyte;
      end else begin
        base_cnt_d[BYTE_W-1:0] = wbyte;
        cur_cnt_d[BYTE_W-1:0]  = wbyte;
      end
    end
    mode_d = mode_q;
    if (mclr)         mode_d = '0;
    else if (mode_wr) mode_d = mode_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_addr <= '0;
      base_cnt  <= '0;
      cur_addr  <= '0;
      cur_cnt   <= '0;
      mode_q    <= '0;
    end else begin
      base_addr <= base_addr_d;
      base_cnt  <= base_cnt_d;
      cur_addr  <= cur_addr_d;
      cur_cnt   <= cur_cnt_d;
      mode_q    <= mode_d;
    end
  end
endmodule

// File: rtl/dmac_regfile.sv
module dmac_regfile
  import dmac_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [3:0]            port_off,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [BYTE_W-1:0]     wdata,
  output logic [BYTE_W-1:0]     rdata,
  input  logic                  step_valid,
  input  logic [CHW-1:0]        step_ch,
  output logic [NCH-1:0]        mask_o,
  output logic [NCH*MODE_W-1:0] mode_o,
  output logic [NCH-1:0]        tc_o
);
  logic                           ptr_hi;
  logic                           chan_acc, is_cnt, mclr, pclr;
  logic [CHW-1:0]                 port_ch;
  logic [NCH-1:0]                 mask_q, mask_d, req_q, req_d, flag_q, flag_d;
  logic [NCH-1:0]                 chan_tc, step_go, auto_v;
  logic [NCH-1:0][WORD_W-1:0]     cur_addr_a, cur_cnt_a;
  logic [NCH-1:0][MODE_W-1:0]     mode_a;
  logic [WORD_W-1:0]              rd_word;
  logic                           stat_rd;

  assign chan_acc = ~port_off[3];
  assign port_ch  = port_off[CHW:1];
  assign is_cnt   = port_off[0];
  assign mclr     = wr_en && (port_off == OFF_MCLR);
  assign pclr     = wr_en && (port_off == OFF_PCLR);
  assign stat_rd  = rd_en && (port_off == OFF_STAT);

  dmac_ptr_ff u_ptr (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (pclr || mclr),
    .tog  ((wr_en || rd_en) && chan_acc),
    .hi_q (ptr_hi)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic port_hit;
    assign port_hit = wr_en && chan_acc && (port_ch == CHW'(i));
    assign step_go[i] = step_valid && (step_ch == CHW'(i)) && !mask_q[i] && !port_hit;
    assign auto_v[i]  = mode_a[i][MODE_AUTO];
    dmac_chan u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .addr_wr (port_hit && !is_cnt),
      .cnt_wr  (port_hit && is_cnt),
      .hi_sel  (ptr_hi),
      .wbyte   (wdata),
      .mode_wr (wr_en && (port_off == OFF_MODE) && (wdata[CHW-1:0] == CHW'(i))),
      .mode_in (wdata[BYTE_W-1:BYTE_W-MODE_W]),
      .mclr    (mclr),
      .step    (step_go[i]),
      .cur_addr(cur_addr_a[i]),
      .cur_cnt (cur_cnt_a[i]),
      .mode_q  (mode_a[i]),
      .tc      (chan_tc[i])
    );
    assign mode_o[i*MODE_W +: MODE_W] = mode_a[i];
  end

  always_comb begin
    mask_d = mask_q;
    req_d  = req_q;
    flag_d = flag_q;
    if (wr_en) begin
      unique case (port_off)
        OFF_MASK1:  mask_d[wdata[CHW-1:0]] = wdata[2];
        OFF_MCLRAL: mask_d = '0;
        OFF_MALL:   mask_d = wdata[NCH-1:0];
        OFF_REQ:    req_d[wdata[CHW-1:0]] = wdata[2];
        default: ;
      endcase
    end
    if (stat_rd) flag_d = '0;
    flag_d = flag_d | chan_tc;
    mask_d = mask_d | (chan_tc & ~auto_v);
    if (mclr) begin
      mask_d = '1;
      req_d  = '0;
      flag_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      req_q  <= '0;
      flag_q <= '0;
      tc_o   <= '0;
    end else begin
      mask_q <= mask_d;
      req_q  <= req_d;
      flag_q <= flag_d;
      tc_o   <= chan_tc;
    end
  end

  assign mask_o  = mask_q;
  assign rd_word = is_cnt ? cur_cnt_a[port_ch] : cur_addr_a[port_ch];

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (chan_acc)     rdata = ptr_hi ? rd_word[WORD_W-1:BYTE_W] : rd_word[BYTE_W-1:0];
      else if (stat_rd) rdata = {req_q, flag_q};
    end
  end
endmodule

// File: rtl/dmac_regfile_chk.sv
module dmac_regfile_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] port_off,
  input logic       wr_en,
  input logic       rd_en,
  input logic [7:0] rdata,
  input logic       step_valid,
  input logic [1:0] step_ch,
  input logic [3:0] mask_o,
  input logic [3:0] tc_o,
  input logic       ptr_hi
);
  // R1
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rdata == 8'h00);
  // R2
  ptr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && port_off == 4'hC |=> !ptr_hi);
  // R2
  ptr_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en ^ rd_en) && !port_off[3] |=> ptr_hi != $past(ptr_hi));
  // R4
  clr_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && port_off == 4'hE && !step_valid |=> mask_o == 4'h0);
  // R7
  masked_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid && mask_o[step_ch] |=> tc_o == 4'h0);
  // R8
  tc_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tc_o));
  // R8
  tc_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tc_o != 4'h0 |-> $past(step_valid));
  // R12
  mclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && port_off == 4'hD |=> mask_o == 4'hF && !ptr_hi);
endmodule

bind dmac_regfile dmac_regfile_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .port_off  (port_off),
  .wr_en     (wr_en),
  .rd_en     (rd_en),
  .rdata     (rdata),
  .step_valid(step_valid),
  .step_ch   (step_ch),
  .mask_o    (mask_o),
  .tc_o      (tc_o),
  .ptr_hi    (ptr_hi)
);

// File: tb/dmac_regfile_bench.sv
`timescale 1ns/100ps
module dmac_regfile_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  port_off;
  logic        wr_en, rd_en, step_valid;
  logic [7:0]  wdata, rdata;
  logic [1:0]  step_ch;
  logic [3:0]  mask_o, tc_o;
  logic [23:0] mode_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  typedef struct {
    int          kind;   // 0 rdata, 1 tc_o, 2 mask_o, 3 mode_o
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  always #2.5 clk = ~clk;

  dmac_regfile u_dmac_regfile (
    .clk(clk), .rst_n(rst_n), .port_off(port_off), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .step_valid(step_valid), .step_ch(step_ch),
    .mask_o(mask_o), .mode_o(mode_o), .tc_o(tc_o)
  );

  // monitor: compares queued expectations 1 ns after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sb.pop_front();
        case (it.kind)
          0: act = {24'h0, rdata};
          1: act = {28'h0, tc_o};
          2: act = {28'h0, mask_o};
          default: act = {8'h0, mode_o};
        endcase
        n_tests++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s: got %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic drive(input logic w, input logic r, input logic [3:0] off,
                       input logic [7:0] d, input logic s, input logic [1:0] ch);
    @(negedge clk);
    wr_en = w; rd_en = r; port_off = off; wdata = d; step_valid = s; step_ch = ch;
  endtask

  task automatic wr(input logic [3:0] off, input logic [7:0] d);
    drive(1'b1, 1'b0, off, d, 1'b0, 2'd0);
  endtask

  task automatic rd(input logic [3:0] off, input logic [7:0] exp, input string tag);
    drive(1'b0, 1'b1, off, 8'h00, 1'b0, 2'd0);
    sb.push_back('{0, {24'h0, exp}, tag});
  endtask

  task automatic idle_chk(input int kind, input logic [31:0] exp, input string tag);
    drive(1'b0, 1'b0, 4'h0, 8'h00, 1'b0, 2'd0);
    sb.push_back('{kind, exp, tag});
  endtask

  task automatic step(input logic [1:0] ch, input logic [3:0] exp_tc, input string tag);
    drive(1'b0, 1'b0, 4'h0, 8'h00, 1'b1, ch);
    idle_chk(1, {28'h0, exp_tc}, tag);
  endtask

  task automatic prog_word(input logic [3:0] off, input logic [15:0] v);
    wr(4'hC, 8'h00);
    wr(off, v[7:0]);
    wr(off, v[15:8]);
  endtask

  task automatic rd_word(input logic [3:0] off, input logic [15:0] exp, input string tag);
    rd(off, exp[7:0], tag);
    rd(off, exp[15:8], tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 0; rd_en = 0; step_valid = 0; port_off = 0; wdata = 0; step_ch = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    idle_chk(2, 32'hF, "R1 mask after reset");
    idle_chk(0, 32'h0, "R1 rdata idle");
    idle_chk(1, 32'h0, "R1 tc idle");
    rd(4'h8, 8'h00, "R1 status after reset");
    // R3 R2 program channel 1 and read back in byte order
    prog_word(4'h2, 16'h1234);
    prog_word(4'h3, 16'h0002);
    rd_word(4'h2, 16'h1234, "R3 ch1 address");
    wr(4'h2, 8'h34);
    wr(4'hC, 8'h00);
    rd_word(4'h2, 16'h1234, "R2 pointer clear mid-pair");
    // R5 mode write, channel in low bits
    wr(4'hB, 8'h49);
    idle_chk(3, 32'h0000_0480, "R5 ch1 mode");
    // R4 single unmask
    wr(4'hA, 8'h01);
    idle_chk(2, 32'hD, "R4 single mask write");
    // R6 steps
    step(2'd1, 4'h0, "R6 step 1");
    step(2'd1, 4'h0, "R6 step 2");
    rd_word(4'h2, 16'h1236, "R6 address incremented");
    rd_word(4'h3, 16'h0000, "R6 count decremented");
    // R8 R9 terminal count without auto-reload
    step(2'd1, 4'h2, "R8 tc pulse ch1");
    idle_chk(2, 32'hF, "R9 tc masks channel");
    rd_word(4'h3, 16'hFFFF, "R8 count reads all ones");
    rd_word(4'h2, 16'h1237, "R6 address after tc");
    // R7 masked step ignored
    step(2'd1, 4'h0, "R7 masked step no tc");
    rd_word(4'h2, 16'h1237, "R7 address unchanged");
    // R10 status flags clear on read
    rd(4'h8, 8'h02, "R10 status tc flag");
    rd(4'h8, 8'h00, "R10 status cleared");
    // R11 request bit
    wr(4'h9, 8'h06);
    rd(4'h8, 8'h40, "R11 request ch2");
    // R5 R9 auto-reload with decrement on channel 2
    prog_word(4'h4, 16'h0010);
    prog_word(4'h5, 16'h0001);
    wr(4'hB, 8'h76);
    idle_chk(3, 32'h0001_D480, "R5 ch2 mode");
    wr(4'hF, 8'h0B);
    idle_chk(2, 32'hB, "R4 write all masks");
    step(2'd2, 4'h0, "R5 decrement step");
    rd_word(4'h4, 16'h000F, "R5 address decremented");
    step(2'd2, 4'h4, "R8 tc pulse ch2");
    idle_chk(2, 32'hB, "R9 auto-reload keeps mask");
    rd_word(4'h4, 16'h0010, "R9 address reloaded");
    rd_word(4'h5, 16'h0001, "R9 count reloaded");
    rd(4'h8, 8'h44, "R10 status request and flag");
    // R4 R6 clear-all masks and 16-bit wrap
    wr(4'hE, 8'h00);
    idle_chk(2, 32'h0, "R4 clear all masks");
    prog_word(4'h0, 16'hFFFF);
    prog_word(4'h1, 16'h0005);
    step(2'd0, 4'h0, "R6 step ch0");
    rd_word(4'h0, 16'h0000, "R6 address wraps");
    rd_word(4'h1, 16'h0004, "R6 count ch0");
    // R12 master clear
    wr(4'h8, 8'h00);
    wr(4'h9, 8'h07);
    wr(4'h0, 8'h77);
    wr(4'hD, 8'h00);
    idle_chk(2, 32'hF, "R12 masks set");
    idle_chk(3, 32'h0, "R12 modes cleared");
    rd(4'h8, 8'h00, "R12 status cleared");
    rd_word(4'h0, 16'h0077, "R12 pointer low and address kept");
    idle_chk(0, 32'h0, "R1 rdata idle at end");
    drive(1'b0, 1'b0, 4'h0, 8'h00, 1'b0, 2'd0);
    @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule